// File: doc/BRIEF.md
# Sequenced Calibration Register Bank

This block stores the trim words used by a converter's correction logic: a gain word, an offset word and eight DAC trim words, each 14 bits wide. A host does not address these words directly. It first issues a control write that picks an access window and a read-enable code. It then issues a series of single-word read or write accesses. An internal pointer steps through the chosen window and moves on by one after every accepted access.

The pointer returns to the start of the window in two cases: when the last word of the window has been accessed, and on any control write. A host can therefore abandon a sequence at any point and start again. Every word that is read back is presented as 16 bits, with the top two bits forced to zero. A separate load port lets an on-chip calibration engine overwrite any word directly by index. If the engine and the host write the same word in the same cycle, the engine's value is kept.

Top module: `cal_bank`

## Requirements
- R1: After reset the offset word (index 1) holds 0x2000 and every other word holds 0. The window is select 00 and the read-enable code is 00.
- R2: The words sit in a fixed order: index 0 gain, index 1 offset, indices 2 to 9 DAC trim words from most to least significant. Select 00 walks all ten words in that order.
- R3: Select 01 walks gain then offset. Select 10 holds offset only. Select 11 holds gain only. The pointer starts on offset only for select 10 and starts on gain for every other select.
- R4: Each accepted read or write moves the pointer on by one inside the window. After the last word of the window it returns to the window start.
- R5: A control write (ctrlWr) captures ctrlSel and ctrlRdSel and puts the pointer back at the window start. Any access presented in the same cycle is ignored, which allows a sequence to be abandoned partway through.
- R6: A read is accepted only while the captured read-enable code is 2'b10. Any other code makes accRd have no effect: there is no rdValid pulse, no pointer movement and no seqDone pulse.
- R7: An accepted read raises rdValid in the next cycle. In that cycle rdData carries the addressed word, with bits 15:14 equal to zero.
- R8: An accepted write stores the 14-bit wrData into the word under the pointer.
- R9: If accRd and accWr are high together, accErr pulses in the next cycle. No word changes, the pointer does not move and no rdValid pulse follows.
- R10: seqDone pulses for one cycle, in the cycle after the access to the last word of the window. This is the same edge at which the pointer returns to the window start.
- R11: engLoad writes engData into the word at engIdx (0 to 9) in any cycle. When a host write hits the same word in the same cycle, the engine value is kept and the host write still advances the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control write strobe |
| ctrlSel | input | 2 | Access window select captured on ctrlWr |
| ctrlRdSel | input | 2 | Read-enable code captured on ctrlWr (2'b10 enables reads) |
| accRd | input | 1 | Read access strobe |
| accWr | input | 1 | Write access strobe |
| wrData | input | 14 | Host write data |
| rdData | output | 16 | Read word, two leading zeros |
| rdValid | output | 1 | rdData valid, one cycle after an accepted read |
| seqDone | output | 1 | Window fully traversed |
| accErr | output | 1 | Read and write requested together |
| engLoad | input | 1 | Calibration engine load strobe |
| engIdx | input | 4 | Word index for the engine load |
| engData | input | 14 | Engine load data |

## Verification
The assertions assume that every strobe is a clean synchronous level for exactly one cycle per access. They also assume that engIdx stays below ten whenever engLoad is high; out-of-range indices are never driven. The bench keeps within these limits: it raises each strobe for a single cycle between two falling edges and returns it low before the next access. It drives the engine port only with valid indices. Its host reads and writes are always either single or a deliberate read-and-write pair.

// File: rtl/cal_bank_pkg.sv
package cal_bank_pkg;

  localparam int NUM_DAC  = 8;
  localparam int NUM_REGS = 2 + NUM_DAC;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int GAIN_IDX = 0;
  localparam int OFFS_IDX = 1;

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [1:0] {
    WIN_ALL  = 2'b00,
    WIN_PAIR = 2'b01,
    WIN_OFFS = 2'b10,
    WIN_GAIN = 2'b11
  } win_t;

  localparam logic [1:0] RDSEL_CAL = 2'b10;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    idx_t idx;
  } strobe_t;

  function automatic idx_t winStart(input win_t w);
    return (w == WIN_OFFS) ? idx_t'(OFFS_IDX) : idx_t'(GAIN_IDX);
  endfunction

  function automatic idx_t winLen(input win_t w);
    case (w)
      WIN_ALL:  return idx_t'(NUM_REGS);
      WIN_PAIR: return idx_t'(2);
      default:  return idx_t'(1);
    endcase
  endfunction

endpackage

// File: rtl/cal_bank_ctrl.sv
module cal_bank_ctrl
  import cal_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic [1:0] ctrlSel,
  input  logic [1:0] ctrlRdSel,
  input  logic       accRd,
  input  logic       accWr,
  output strobe_t    stb,
  output idx_t       curIdx,
  output logic       seqDone,
  output logic       accErr
);

  win_t       winQ;
  logic [1:0] rdSelQ;
  idx_t       cntQ;

  logic conflict;
  logic doWr;
  logic doRd;
  logic access;
  logic lastPos;

  always_comb begin
    conflict = accRd && accWr && !ctrlWr;
    doWr     = accWr && !accRd && !ctrlWr;
    doRd     = accRd && !accWr && !ctrlWr && (rdSelQ == RDSEL_CAL);
    access   = doWr || doRd;
    lastPos  = (cntQ == winLen(winQ) - idx_t'(1));
    curIdx   = winStart(winQ) + cntQ;
    stb.wrEn = doWr;
    stb.rdEn = doRd;
    stb.idx  = curIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winQ    <= WIN_ALL;
      rdSelQ  <= 2'b00;
      cntQ    <= '0;
      seqDone <= 1'b0;
      accErr  <= 1'b0;
    end else begin
      seqDone <= access && lastPos;
      accErr  <= conflict;
      if (ctrlWr) begin
        winQ   <= win_t'(ctrlSel);
        rdSelQ <= ctrlRdSel;
        cntQ   <= '0;
      end else if (access) begin
        cntQ <= lastPos ? '0 : cntQ + idx_t'(1);
      end
    end
  end

endmodule

// File: rtl/cal_bank_dp.sv
module cal_bank_dp
  import cal_bank_pkg::*;
#(
  parameter int              DATA_W   = 14,
  parameter int              WORD_W   = 16,
  parameter logic [DATA_W-1:0] GAIN_RST = '0,
  parameter logic [DATA_W-1:0] OFFS_RST = DATA_W'(14'h2000),
  parameter logic [DATA_W-1:0] DAC_RST  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              engLoad,
  input  idx_t              engIdx,
  input  logic [DATA_W-1:0] engData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);

  localparam int PAD_W = WORD_W - DATA_W;

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
    localparam logic [DATA_W-1:0] RST_VAL =
      (gi == OFFS_IDX) ? OFFS_RST : ((gi == GAIN_IDX) ? GAIN_RST : DAC_RST);
    logic engHit;
    logic hostHit;
    assign engHit  = engLoad && (engIdx == idx_t'(gi));
    assign hostHit = stb.wrEn && (stb.idx == idx_t'(gi));
    always_ff @(posedge clk) begin
      if (!rstN)        regs[gi] <= RST_VAL;
      else if (engHit)  regs[gi] <= engData;
      else if (hostHit) regs[gi] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= {{PAD_W{1'b0}}, regs[stb.idx]};
    end
  end

endmodule

// File: rtl/cal_bank.sv
module cal_bank
  import cal_bank_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [1:0]        ctrlSel,
  input  logic [1:0]        ctrlRdSel,
  input  logic              accRd,
  input  logic              accWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              seqDone,
  output logic              accErr,
  input  logic              engLoad,
  input  logic [IDX_W-1:0]  engIdx,
  input  logic [DATA_W-1:0] engData
);

  strobe_t stb;
  idx_t    curIdx;

  cal_bank_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .ctrlSel   (ctrlSel),
    .ctrlRdSel (ctrlRdSel),
    .accRd     (accRd),
    .accWr     (accWr),
    .stb       (stb),
    .curIdx    (curIdx),
    .seqDone   (seqDone),
    .accErr    (accErr)
  );

  cal_bank_dp #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .engLoad (engLoad),
    .engIdx  (engIdx),
    .engData (engData),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/cal_bank_chk.sv
module cal_bank_chk
  import cal_bank_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWr,
  input logic              accRd,
  input logic              accWr,
  input logic [WORD_W-1:0] rdData,
  input logic              rdValid,
  input logic              seqDone,
  input logic              accErr,
  input idx_t              curIdx
);

  // R7: returned words always carry two zero leading bits
  a_r7_lead_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[WORD_W-1:WORD_W-2] == 2'b00));

  // R7: valid data only follows a lone read request
  a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(accRd) || $past(accWr) || $past(ctrlWr)) |-> !rdValid);

  // R9: a read-and-write pair flags an error and returns nothing
  a_r9_conflict_flag: assert property (@(posedge clk) disable iff (!rstN)
    (accRd && accWr && !ctrlWr) |=> (accErr && !rdValid && !seqDone));

  // R9: the pointer stays put on a conflicting request
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (accRd && accWr && !ctrlWr) |=> $stable(curIdx));

  // R5: a control write returns the pointer to a window start and ends nothing
  a_r5_ctrl_restart: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (!seqDone && !rdValid && (curIdx <= idx_t'(OFFS_IDX))));

  // R10: completion only follows an access
  a_r10_done_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> ($past(accRd ^ accWr) && !$past(ctrlWr)));

  // R2: the pointer never leaves the register range
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    curIdx < idx_t'(NUM_REGS));

endmodule

bind cal_bank cal_bank_chk #(.WORD_W(WORD_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .ctrlWr  (ctrlWr),
  .accRd   (accRd),
  .accWr   (accWr),
  .rdData  (rdData),
  .rdValid (rdValid),
  .seqDone (seqDone),
  .accErr  (accErr),
  .curIdx  (curIdx)
);

// File: tb/cal_bank_tb_top.sv
module cal_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [1:0]  ctrlSel = 2'b00;
  logic [1:0]  ctrlRdSel = 2'b00;
  logic        accRd = 1'b0;
  logic        accWr = 1'b0;
  logic [13:0] wrData = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic        seqDone;
  logic        accErr;
  logic        engLoad = 1'b0;
  logic [3:0]  engIdx = '0;
  logic [13:0] engData = '0;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  int expReg [10];
  int curSel = 0;
  int curRd = 0;
  int cnt = 0;

  always #2.5 clk = ~clk;

  cal_bank dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlSel(ctrlSel),
    .ctrlRdSel(ctrlRdSel), .accRd(accRd), .accWr(accWr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .seqDone(seqDone), .accErr(accErr),
    .engLoad(engLoad), .engIdx(engIdx), .engData(engData)
  );

  function automatic int wStart(int s);
    return (s == 2) ? 1 : 0;
  endfunction

  function automatic int wLen(int s);
    return (s == 0) ? 10 : ((s == 1) ? 2 : 1);
  endfunction

  task automatic check(string req, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ctrl(int s, int r);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlSel = 2'(s); ctrlRdSel = 2'(r);
    accRd = 1'b1;  // ignored during a control write (R5)
    @(negedge clk);
    ctrlWr = 1'b0; accRd = 1'b0;
    check("R5 no read during control write", int'(rdValid), 0);
    curSel = s; curRd = r; cnt = 0;
  endtask

  task automatic advance(output bit last);
    last = (cnt == wLen(curSel) - 1);
    cnt = last ? 0 : cnt + 1;
  endtask

  task automatic hostWr(int d);
    bit last;
    int idx = wStart(curSel) + cnt;
    @(negedge clk);
    accWr = 1'b1; wrData = 14'(d);
    @(negedge clk);
    accWr = 1'b0;
    expReg[idx] = d & 16'h3fff;
    advance(last);
    check("R10 seqDone after write", int'(seqDone), int'(last));
  endtask

  task automatic hostRd(string req);
    bit last;
    int idx = wStart(curSel) + cnt;
    @(negedge clk);
    accRd = 1'b1;
    @(negedge clk);
    accRd = 1'b0;
    if (curRd == 2) begin
      advance(last);
      check({req, " rdValid"}, int'(rdValid), 1);
      check({req, " R7 data"}, int'(rdData), expReg[idx]);
      check({req, " R10 seqDone"}, int'(seqDone), int'(last));
    end else begin
      check({req, " R6 read ignored rdValid"}, int'(rdValid), 0);
      check({req, " R6 read ignored seqDone"}, int'(seqDone), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 10; i++) expReg[i] = (i == 1) ? 16'h2000 : 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset rdValid", int'(rdValid), 0);
    check("R1 reset seqDone", int'(seqDone), 0);
    check("R1 reset accErr", int'(accErr), 0);
    hostRd("R1 reset read code 00");

    // R1 R2: reset contents in fixed order
    ctrl(0, 2);
    for (int i = 0; i < 10; i++) hostRd("R1 R2 reset contents");

    // R8 R4: fill all, then read two full passes
    ctrl(0, 0);
    for (int i = 0; i < 10; i++) hostWr((i * 1237 + 5) & 16'h3fff);
    ctrl(0, 2);
    for (int i = 0; i < 20; i++) hostRd("R8 R4 wrap pass");

    // R3 R6: each narrow window, every read-enable code
    for (int s = 1; s < 4; s++) begin
      ctrl(s, 0);
      for (int i = 0; i < wLen(s); i++) hostWr(16'h3000 + s * 16 + i);
      for (int r = 0; r < 4; r++) begin
        ctrl(s, r);
        for (int i = 0; i < 2 * wLen(s) + 1; i++) hostRd("R3 window");
      end
    end

    // R5: abandon partway and restart
    ctrl(0, 2);
    for (int i = 0; i < 3; i++) hostRd("R5 partial");
    ctrl(0, 2);
    for (int i = 0; i < 10; i++) hostRd("R5 restart");

    // R9: conflicting request
    ctrl(0, 2);
    hostRd("R9 lead-in");
    @(negedge clk);
    accRd = 1'b1; accWr = 1'b1; wrData = 14'h1555;
    @(negedge clk);
    accRd = 1'b0; accWr = 1'b0;
    check("R9 accErr", int'(accErr), 1);
    check("R9 no rdValid", int'(rdValid), 0);
    check("R9 no seqDone", int'(seqDone), 0);
    for (int i = 0; i < 9; i++) hostRd("R9 pointer held, words intact");

    // R11: engine beats host on the same word, loads other words alone
    ctrl(3, 0);
    @(negedge clk);
    accWr = 1'b1; wrData = 14'h0aaa;
    engLoad = 1'b1; engIdx = 4'd0; engData = 14'h2b2b;
    @(negedge clk);
    accWr = 1'b0; engLoad = 1'b0;
    check("R11 host write still completes window", int'(seqDone), 1);
    expReg[0] = 16'h2b2b;
    @(negedge clk);
    engLoad = 1'b1; engIdx = 4'd5; engData = 14'h1c3d;
    @(negedge clk);
    engLoad = 1'b0;
    expReg[5] = 16'h1c3d;
    ctrl(0, 2);
    for (int i = 0; i < 10; i++) hostRd("R11 engine load");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nVec++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule